// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block passes an 18-bit word between two ports, called A and B, in either direction. Each direction owns one storage word. The word can follow its source port, keep its value, or take a new value when that direction's capture strobe falls. The A-to-B word feeds the B port and the B-to-A word feeds the A port. Three controls steer each direction: a transparency enable, a capture strobe and a drive enable. Because the block sits inside a synchronous design, each port is split into a data input, a data output and a drive-enable output instead of a tri-state pin.

All storage is timed by the system clock `clk`. Each capture strobe is an ordinary input sampled on that clock. A high-to-low change between two consecutive samples counts as a falling edge. A new value reaches the data output one clock after it is accepted. The drive-enable outputs come straight from the enable pins with no register in between. The active level of each drive enable is a parameter.

Top module: `bus_xcvr18`

## Requirements
- R1: While `srst` is high at a clock edge, both storage words become zero, so `b_dout` and `a_dout` read 0 after that edge.
- R2: While `ab_tpen` is high at a clock edge, the A-to-B word takes `a_din`, and `b_dout` shows it after that edge.
- R3: While `ab_tpen` is low and `ab_cap` is sampled high at this edge and at the edge before, the A-to-B word does not change.
- R4: While `ab_tpen` is low and `ab_cap` is sampled low at this edge and at the edge before, the A-to-B word does not change.
- R5: While `ab_tpen` is low, if `ab_cap` was sampled high at the previous edge and is sampled low at this edge, the A-to-B word takes `a_din` at this edge.
- R6: While `ab_tpen` is low, a rise of `ab_cap` (low at the previous edge, high at this edge) leaves the A-to-B word unchanged.
- R7: `b_oe` is 1 exactly when `ab_oe` equals its active level, which is high by default. `b_oe` follows the pin with no clock delay.
- R8: `a_oe` is 1 exactly when `ba_oe` equals its active level, which is low by default. `a_oe` follows the pin with no clock delay.
- R9: The B-to-A direction obeys R2 to R6 using `ba_tpen`, `ba_cap` and `b_din`, and drives `a_dout`. Activity on either direction never changes the word of the other direction.
- R10: A fall of the capture strobe while the transparency enable is high gives the same result as the transparent mode alone: the word takes the current input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| a_din | input | 18 | Data arriving on the A port |
| b_din | input | 18 | Data arriving on the B port |
| ab_tpen | input | 1 | A-to-B transparency enable |
| ab_cap | input | 1 | A-to-B capture strobe; a fall stores the data |
| ab_oe | input | 1 | B port drive enable pin |
| ba_tpen | input | 1 | B-to-A transparency enable |
| ba_cap | input | 1 | B-to-A capture strobe; a fall stores the data |
| ba_oe | input | 1 | A port drive enable pin |
| a_dout | output | 18 | B-to-A word presented to the A port |
| a_oe | output | 1 | A port driver active |
| b_dout | output | 18 | A-to-B word presented to the B port |
| b_oe | output | 1 | B port driver active |

## Verification
Each storage word is visible at its data output one clock after every edge. A bad capture, a lost hold or a crossed direction therefore shows up at the ports on the next clock. The bench compares both words against its own model on every clock, so a fault is caught in the cycle it appears. It does not wait for a later readback. Drive-enable faults have no delay and are checked a fraction of a cycle after the pin changes.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

    localparam int unsigned XCVR_WIDTH = 18;
    localparam int unsigned NUM_DIRS   = 2;
    localparam int unsigned DIR_AB     = 0;
    localparam int unsigned DIR_BA     = 1;

    typedef enum logic [1:0] {
        ST_FOLLOW  = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_KEEP    = 2'd2
    } store_mode_e;

    typedef struct packed {
        logic tpen;
        logic cap;
        logic oe;
    } dir_ctrl_t;

    function automatic store_mode_e pick_mode(logic tpen, logic cap_prev, logic cap_now);
        if (tpen)
            return ST_FOLLOW;
        else if (cap_prev && !cap_now)
            return ST_CAPTURE;
        else
            return ST_KEEP;
    endfunction

    function automatic logic oe_is_active(logic pin, bit active_high);
        return active_high ? pin : !pin;
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store
    import bus_xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_WIDTH
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             tpen,
    input  logic             cap,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic        cap_prev;
    store_mode_e mode;

    always_comb begin
        mode = pick_mode(tpen, cap_prev, cap);
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            cap_prev <= 1'b0;
            q        <= '0;
        end else begin
            cap_prev <= cap;
            unique case (mode)
                ST_FOLLOW,
                ST_CAPTURE: q <= d;
                default:    q <= q;
            endcase
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) srst |=> q == '0);
    p_follow_r2: assert property (@(posedge clk) disable iff (srst)
        tpen |=> q == $past(d));
    p_keep_high_r3: assert property (@(posedge clk) disable iff (srst)
        (!tpen && cap_prev && cap) |=> $stable(q));
    p_keep_low_r4: assert property (@(posedge clk) disable iff (srst)
        (!tpen && !cap_prev && !cap) |=> $stable(q));
    p_fall_capture_r5: assert property (@(posedge clk) disable iff (srst)
        (!tpen && cap_prev && !cap) |=> q == $past(d));
    p_rise_ignored_r6: assert property (@(posedge clk) disable iff (srst)
        (!tpen && !cap_prev && cap) |=> $stable(q));

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
    import bus_xcvr_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic oe_pin,
    output logic drive_en
);

    always_comb begin
        drive_en = oe_is_active(oe_pin, ACTIVE_HIGH);
    end

endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18
    import bus_xcvr_pkg::*;
#(
    parameter int unsigned WIDTH      = XCVR_WIDTH,
    parameter bit          AB_OE_HIGH = 1'b1,
    parameter bit          BA_OE_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             srst,
    input  logic [WIDTH-1:0] a_din,
    input  logic [WIDTH-1:0] b_din,
    input  logic             ab_tpen,
    input  logic             ab_cap,
    input  logic             ab_oe,
    input  logic             ba_tpen,
    input  logic             ba_cap,
    input  logic             ba_oe,
    output logic [WIDTH-1:0] a_dout,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_dout,
    output logic             b_oe
);

    localparam int unsigned NDIR = NUM_DIRS;

    dir_ctrl_t        ctrl    [NDIR];
    logic [WIDTH-1:0] src     [NDIR];
    logic [WIDTH-1:0] word    [NDIR];
    logic             drv     [NDIR];

    always_comb begin
        ctrl[DIR_AB] = '{tpen: ab_tpen, cap: ab_cap, oe: ab_oe};
        ctrl[DIR_BA] = '{tpen: ba_tpen, cap: ba_cap, oe: ba_oe};
        src[DIR_AB]  = a_din;
        src[DIR_BA]  = b_din;
    end

    for (genvar i = 0; i < NDIR; i++) begin : g_dir
        localparam bit OE_HIGH = (i == DIR_AB) ? AB_OE_HIGH : BA_OE_HIGH;

        xcvr_store #(.WIDTH(WIDTH)) u_store (
            .clk  (clk),
            .srst (srst),
            .tpen (ctrl[i].tpen),
            .cap  (ctrl[i].cap),
            .d    (src[i]),
            .q    (word[i])
        );

        xcvr_drive #(.ACTIVE_HIGH(OE_HIGH)) u_drive (
            .oe_pin   (ctrl[i].oe),
            .drive_en (drv[i])
        );
    end

    always_comb begin
        b_dout = word[DIR_AB];
        b_oe   = drv[DIR_AB];
        a_dout = word[DIR_BA];
        a_oe   = drv[DIR_BA];
    end

    p_ab_steady_r9: assert property (@(posedge clk) disable iff (srst)
        (!ab_tpen && $stable(ab_cap)) |=> $stable(b_dout));
    p_ba_steady_r9: assert property (@(posedge clk) disable iff (srst)
        (!ba_tpen && $stable(ba_cap)) |=> $stable(a_dout));

endmodule

// File: tb/bus_xcvr18_tb_top.sv
`timescale 1ns/1ps
module bus_xcvr18_tb_top;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         srst = 1'b1;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic         ab_tpen = 1'b0, ab_cap = 1'b0, ab_oe = 1'b0;
    logic         ba_tpen = 1'b0, ba_cap = 1'b0, ba_oe = 1'b1;
    logic [W-1:0] a_dout, b_dout;
    logic         a_oe, b_oe;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    done     = 0;
    string phase    = "R1";

    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic         m_ab_last = 1'b0, m_ba_last = 1'b0;

    always #2 clk = ~clk;

    bus_xcvr18 dut_i (
        .clk(clk), .srst(srst), .a_din(a_din), .b_din(b_din),
        .ab_tpen(ab_tpen), .ab_cap(ab_cap), .ab_oe(ab_oe),
        .ba_tpen(ba_tpen), .ba_cap(ba_cap), .ba_oe(ba_oe),
        .a_dout(a_dout), .a_oe(a_oe), .b_dout(b_dout), .b_oe(b_oe)
    );

    // Behavioural reference: what each word should be after every edge
    always @(posedge clk) begin
        if (srst) begin
            m_ab = '0; m_ba = '0; m_ab_last = 1'b0; m_ba_last = 1'b0;
        end else begin
            if (ab_tpen || (m_ab_last === 1'b1 && ab_cap === 1'b0)) m_ab = a_din;
            if (ba_tpen || (m_ba_last === 1'b1 && ba_cap === 1'b0)) m_ba = b_din;
            m_ab_last = ab_cap;
            m_ba_last = ba_cap;
        end
    end

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model comparison on every clock, half a period after the edge
    always @(negedge clk) begin
        if (!srst && !done) begin
            chk({phase, " model B word"}, b_dout, m_ab);
            chk({phase, " model A word"}, a_dout, m_ba);
            chk("R7 model b_oe", {17'd0, b_oe}, {17'd0, ab_oe === 1'b1});
            chk("R8 model a_oe", {17'd0, a_oe}, {17'd0, ba_oe === 1'b0});
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        a_din = 18'h3FFFF; b_din = 18'h2AAAA;
        step(3);
        chk("R1 reset B word", b_dout, '0);
        chk("R1 reset A word", a_dout, '0);
        srst = 1'b0;

        phase = "R2";
        ab_tpen = 1'b1; a_din = 18'h2A5A5;
        step();
        chk("R2 follow 1", b_dout, 18'h2A5A5);
        a_din = 18'h15A5A;
        step();
        chk("R2 follow 2", b_dout, 18'h15A5A);

        phase = "R4";
        ab_tpen = 1'b0;
        step();
        a_din = 18'h3FFFF;
        step(3);
        chk("R4 keep with strobe low", b_dout, 18'h15A5A);

        phase = "R6";
        ab_cap = 1'b1;
        step();
        chk("R6 rise ignored", b_dout, 18'h15A5A);

        phase = "R3";
        a_din = 18'h00001;
        step(3);
        chk("R3 keep with strobe high", b_dout, 18'h15A5A);

        phase = "R5";
        a_din = 18'h12345; ab_cap = 1'b0;
        step();
        chk("R5 fall capture", b_dout, 18'h12345);
        a_din = 18'h0BEEF;
        step(2);
        chk("R5 no recapture after fall", b_dout, 18'h12345);

        phase = "R10";
        ab_cap = 1'b1; step();
        ab_tpen = 1'b1; ab_cap = 1'b0; a_din = 18'h2F0F0;
        step();
        chk("R10 fall while transparent", b_dout, 18'h2F0F0);
        ab_tpen = 1'b0; step();

        ab_oe = 1'b1; #1;
        chk("R7 b_oe on", {17'd0, b_oe}, 18'd1);
        ab_oe = 1'b0; #1;
        chk("R7 b_oe off", {17'd0, b_oe}, 18'd0);
        ba_oe = 1'b0; #1;
        chk("R8 a_oe on", {17'd0, a_oe}, 18'd1);
        ba_oe = 1'b1; #1;
        chk("R8 a_oe off", {17'd0, a_oe}, 18'd0);

        phase = "R9";
        a_din = 18'h3C3C3;
        ba_tpen = 1'b1; b_din = 18'h01234;
        step();
        chk("R9 B-to-A follow", a_dout, 18'h01234);
        chk("R9 A-to-B untouched", b_dout, 18'h2F0F0);
        ba_tpen = 1'b0; ba_cap = 1'b1; b_din = 18'h3AAAA;
        step(2);
        chk("R9 B-to-A rise ignored/keep", a_dout, 18'h01234);
        ba_cap = 1'b0;
        step();
        chk("R9 B-to-A fall capture", a_dout, 18'h3AAAA);
        b_din = 18'h05555;
        step(2);
        chk("R9 B-to-A keep low", a_dout, 18'h3AAAA);
        ab_tpen = 1'b1;
        step();
        chk("R9 A-to-B follow with B-to-A idle", b_dout, 18'h3C3C3);
        chk("R9 B-to-A untouched", a_dout, 18'h3AAAA);
        ab_tpen = 1'b0;

        phase = "R1";
        srst = 1'b1;
        step();
        chk("R1 second reset B", b_dout, '0);
        chk("R1 second reset A", a_dout, '0);
        step();
        finish_run();
    end

endmodule